// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a victim frame among a fixed set of physical frames with a second-chance sweep. Each frame has one use bit. The reference port sets a frame's use bit whenever that frame is accessed. A single hand points at one frame of the circle.

When a fault request arrives, the hand sweeps forward one frame per clock cycle. Each frame it passes with its use bit set gets a second chance: the bit is cleared and the hand moves on. The first frame whose use bit is clear becomes the victim. The block then reports that frame with a one-cycle done pulse and leaves the hand on the next frame.

If every use bit is set, the sweep goes all the way round, clearing each bit. It then picks the frame it started from, which gives first-in first-out order. The hand moves only while serving a fault. Loading the page and updating tables are left to the surrounding logic.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all use bits are clear, the hand is on frame 0, and `busy_o` and `done_o` are low. The first fault therefore returns frame 0.
- R2: A reference to frame f (`ref_valid_i` high, `ref_frame_i` = f) sets that frame's use bit. A later sweep then passes over frame f instead of choosing it.
- R3: When the sweep reaches a frame whose use bit is set, it clears that bit and moves on. A following sweep that reaches that frame chooses it unless it was referenced again.
- R4: The victim is the first frame with a clear use bit, counting from the hand. After a victim is reported, the hand points to the frame after the victim.
- R5: If all use bits are set when a fault is accepted, all of them are cleared and the victim is the frame the sweep started from.
- R6: A fault sampled at clock edge E0 makes `busy_o` high after E0. Each later edge examines one frame. When k set frames precede the victim, `done_o` is high for exactly one cycle after edge E0+k+1, with `victim_frame_o` valid in that cycle and `busy_o` low again.
- R7: If a reference to a frame arrives in the same cycle the sweep examines that frame, the reference wins. The bit stays set and the sweep still moves past the frame.
- R8: A fault request while `busy_o` is high is ignored. The hand never moves without an accepted fault, whatever references arrive.
- R9: The hand wraps from frame NUM_FRAMES-1 to frame 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_valid_i | input | 1 | An access to frame `ref_frame_i` took place this cycle |
| ref_frame_i | input | IDX_W | Index of the accessed frame |
| fault_req_i | input | 1 | Request to choose a victim; taken only when idle |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse: victim reported |
| victim_frame_o | output | IDX_W | Victim frame index, valid when `done_o` is high |

## Verification
A fault the bench drives before edge E0 gives `done_o` after edge E0+k+1. Here k is the number of set frames the bench expects the hand to pass, so the pulse is due k+2 falling edges after the request was applied. The bench samples all outputs on falling edges and counts those edges from the request. It compares the count with k+2, checks the victim index in the same sample, and checks one falling edge later that the pulse has dropped. The same counting gives NUM_FRAMES+2 for a full wrap, and one more cycle when a reference held on the start frame keeps that frame alive.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;

  function automatic int unsigned idx_width(input int unsigned frames);
    return (frames > 1) ? $clog2(frames) : 1;
  endfunction

endpackage

// File: rtl/use_bit_array.sv
module use_bit_array #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = clock_sel_pkg::idx_width(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_en_i,
  input  logic [IDX_W-1:0]      set_frame_i,
  input  logic                  clr_en_i,
  input  logic [IDX_W-1:0]      clr_frame_i,
  output logic [NUM_FRAMES-1:0] use_q_o
);

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic set_hit;
    logic clr_hit;
    logic bit_en;
    logic bit_d;
    logic bit_q;

    always_comb begin
      set_hit = set_en_i && (set_frame_i == IDX_W'(g));
      clr_hit = clr_en_i && (clr_frame_i == IDX_W'(g));
      bit_en  = set_hit || clr_hit;
      // reference wins over the sweep clear
      bit_d   = set_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign use_q_o[g] = bit_q;
  end

endmodule

// File: rtl/clock_hand.sv
module clock_hand #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = clock_sel_pkg::idx_width(NUM_FRAMES),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_en_i,
  output logic [IDX_W-1:0] hand_q_o
);

  logic [IDX_W-1:0] hand_d;
  logic [IDX_W-1:0] hand_q;

  always_comb begin
    if (hand_q == LAST_IDX) begin
      hand_d = '0;
    end else begin
      hand_d = hand_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hand_q <= '0;
    end else if (adv_en_i) begin
      hand_q <= hand_d;
    end
  end

  assign hand_q_o = hand_q;

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = clock_sel_pkg::idx_width(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_req_i,
  input  logic             cur_use_i,
  input  logic [IDX_W-1:0] hand_i,
  output logic             sweep_o,
  output logic             clr_en_o,
  output logic             adv_en_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_o
);

  import clock_sel_pkg::*;

  sweep_state_e state_d;
  sweep_state_e state_q;
  logic         found;
  logic         done_d;
  logic         done_q;
  logic [IDX_W-1:0] victim_q;

  always_comb begin
    state_d  = state_q;
    found    = 1'b0;
    clr_en_o = 1'b0;
    adv_en_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fault_req_i) begin
          state_d = ST_SWEEP;
        end
      end
      ST_SWEEP: begin
        adv_en_o = 1'b1;
        if (cur_use_i) begin
          clr_en_o = 1'b1;
        end else begin
          found   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = found;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_q <= '0;
    end else if (found) begin
      victim_q <= hand_i;
    end
  end

  assign sweep_o  = (state_q == ST_SWEEP);
  assign done_o   = done_q;
  assign victim_o = victim_q;

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = clock_sel_pkg::idx_width(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_valid_i,
  input  logic [IDX_W-1:0] ref_frame_i,
  input  logic             fault_req_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_frame_o
);

  logic                  ref_ok;
  logic [NUM_FRAMES-1:0] use_q;
  logic [IDX_W-1:0]      hand_q;
  logic                  cur_use;
  logic                  sweep;
  logic                  clr_en;
  logic                  adv_en;

  if (NUM_FRAMES == (1 << IDX_W)) begin : g_full_range
    assign ref_ok = ref_valid_i;
  end else begin : g_part_range
    assign ref_ok = ref_valid_i && (ref_frame_i < IDX_W'(NUM_FRAMES));
  end

  use_bit_array #(.NUM_FRAMES(NUM_FRAMES)) u_use (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_en_i    (ref_ok),
    .set_frame_i (ref_frame_i),
    .clr_en_i    (clr_en),
    .clr_frame_i (hand_q),
    .use_q_o     (use_q)
  );

  clock_hand #(.NUM_FRAMES(NUM_FRAMES)) u_hand (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_en_i (adv_en),
    .hand_q_o (hand_q)
  );

  assign cur_use = use_q[hand_q];

  sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_req_i (fault_req_i),
    .cur_use_i   (cur_use),
    .hand_i      (hand_q),
    .sweep_o     (sweep),
    .clr_en_o    (clr_en),
    .adv_en_o    (adv_en),
    .done_o      (done_o),
    .victim_o    (victim_frame_o)
  );

  assign busy_o = sweep;

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = clock_sel_pkg::idx_width(NUM_FRAMES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ref_ok_i,
  input logic [IDX_W-1:0]      ref_frame_i,
  input logic                  fault_req_i,
  input logic                  sweep_i,
  input logic [IDX_W-1:0]      hand_i,
  input logic [NUM_FRAMES-1:0] use_i,
  input logic                  done_i,
  input logic [IDX_W-1:0]      victim_i
);

  logic [IDX_W-1:0] hand_d;
  logic [IDX_W-1:0] ref_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hand_d <= '0;
      ref_d  <= '0;
    end else begin
      hand_d <= hand_i;
      ref_d  <= ref_frame_i;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R6

  AST_VICTIM_FOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_i && !use_i[hand_i]) |=> (done_i && victim_i == hand_d && !sweep_i)); // R4

  AST_SWEEP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_i && use_i[hand_i] && !(ref_ok_i && ref_frame_i == hand_i)) |=> !use_i[hand_d]); // R3

  AST_REF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ok_i |=> use_i[ref_d]); // R2 R7

  AST_HAND_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sweep_i |=> $stable(hand_i)); // R8

  AST_HAND_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_i && hand_i == IDX_W'(NUM_FRAMES - 1)) |=> (hand_i == '0)); // R9

  AST_IDLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sweep_i && fault_req_i) |=> (sweep_i && !done_i)); // R6

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_ok_i    (ref_ok),
  .ref_frame_i (ref_frame_i),
  .fault_req_i (fault_req_i),
  .sweep_i     (sweep),
  .hand_i      (hand_q),
  .use_i       (use_q),
  .done_i      (done_o),
  .victim_i    (victim_frame_o)
);

// File: tb/test_clock_victim_sel.sv
module test_clock_victim_sel;

  localparam int unsigned NF  = 8;
  localparam int unsigned IW  = 3;

  logic          clk;
  logic          rst_n;
  logic          ref_valid;
  logic [IW-1:0] ref_frame;
  logic          fault;
  logic          busy;
  logic          done;
  logic [IW-1:0] victim;

  int n_checks = 0;
  int n_errors = 0;

  clock_victim_sel #(.NUM_FRAMES(NF)) i_clock_victim_sel (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ref_valid_i    (ref_valid),
    .ref_frame_i    (ref_frame),
    .fault_req_i    (fault),
    .busy_o         (busy),
    .done_o         (done),
    .victim_frame_o (victim)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic touch(input int f);
    ref_valid = 1'b1;
    ref_frame = IW'(f);
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic touch_all();
    for (int f = 0; f < NF; f++) touch(f);
  endtask

  // issues a fault, measures falling edges until done, checks victim and pulse width
  task automatic run_fault(input int exp_v, input int exp_lat, input bit poke, input string req);
    int lat;
    bit seen;
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    lat  = 1;
    seen = 1'b0;
    while (!seen && lat < 40) begin
      if (done) begin
        seen = 1'b1;
      end else begin
        fault = poke && (lat == 2 || lat == 3);
        @(negedge clk);
        fault = 1'b0;
        lat++;
      end
    end
    check(seen, req, int'(seen), 1);
    check(lat == exp_lat, req, lat, exp_lat);
    check(int'(victim) == exp_v, req, int'(victim), exp_v);
    check(!busy, req, int'(busy), 0);
    @(negedge clk);
    check(!done, "R6 pulse width", int'(done), 0);
  endtask

  task automatic t_reset();
    check(!busy && !done, "R1 reset outputs", int'({busy, done}), 0);
    run_fault(0, 2, 1'b0, "R1 first victim");
  endtask

  task automatic t_advance();
    run_fault(1, 2, 1'b0, "R4 hand past victim");
    run_fault(2, 2, 1'b0, "R4 hand past victim");
  endtask

  task automatic t_second_chance();
    touch(3);
    touch(4);
    run_fault(5, 4, 1'b0, "R2 R6 skip referenced");
    run_fault(6, 2, 1'b0, "R4 next");
    run_fault(7, 2, 1'b0, "R4 last frame");
    run_fault(0, 2, 1'b0, "R9 wrap");
    run_fault(1, 2, 1'b0, "R4 after wrap");
    run_fault(2, 2, 1'b0, "R4 after wrap");
    run_fault(3, 2, 1'b0, "R3 cleared bit chosen");
  endtask

  task automatic t_all_set();
    touch_all();
    run_fault(4, NF + 2, 1'b0, "R5 full wrap");
    run_fault(5, 2, 1'b0, "R5 bits cleared");
  endtask

  task automatic t_busy_ignore();
    int extra;
    touch_all();
    run_fault(6, NF + 2, 1'b1, "R8 fault while busy");
    extra = 0;
    for (int i = 0; i < 3; i++) begin
      if (done || busy) extra++;
      @(negedge clk);
    end
    check(extra == 0, "R8 no second sweep", extra, 0);
    run_fault(7, 2, 1'b0, "R8 hand moved once");
  endtask

  task automatic t_ref_priority();
    touch_all();
    ref_valid = 1'b1;
    ref_frame = IW'(0);
    run_fault(1, NF + 3, 1'b0, "R7 reference beats clear");
    ref_valid = 1'b0;
  endtask

  task automatic t_idle_refs();
    for (int i = 0; i < 3; i++) touch(5);
    run_fault(2, 2, 1'b0, "R8 hand still on idle refs");
    run_fault(3, 2, 1'b0, "R4 next");
    run_fault(4, 2, 1'b0, "R4 next");
    run_fault(6, 3, 1'b0, "R2 idle ref skipped");
    run_fault(7, 2, 1'b0, "R4 next");
    run_fault(1, 3, 1'b0, "R7 kept bit skipped");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    ref_valid = 1'b0;
    ref_frame = '0;
    fault     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_advance();
    t_second_chance();
    t_all_set();
    t_busy_ignore();
    t_ref_priority();
    t_idle_refs();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule